// File: doc/BRIEF.md
# Parallel Bus Register Slave

This block is a small memory-mapped slave that hangs off an 8-bit slice of a host processor's parallel bus. The host selects it with an active-low chip select, presents a 6-bit address and a read/write level, and moves data over the upper byte lane of its 16-bit data bus. The block answers reads combinationally from its register bank, and it commits writes on its own clock once the deasserting edge of chip select has passed a two-flop synchroniser. Because nothing is tied to the host clock, the same logic serves the host at full bus speed and at half speed without any setting.

The address window is split by its most significant bit. The lower half belongs to the user. The upper half is reserved, and there the block neither drives data nor accepts writes. In the user half, offsets 0 to 6 are plain 8-bit registers, and offset 6 also holds the interrupt enable. Offset 7 is a status register that reports and controls a pending-interrupt flag. Local logic raises the flag with a one-cycle event pulse. The flag drives an active-low, level-held interrupt line, which stays asserted until software clears it.

Top module: `exp_bus_slave`

## Requirements
- R1: While rst_n is low, registers 0 to 6 and the pending flag are 0. After reset, each register reads back 0, irq_n is 1, and with bus_cs_n high bus_doe and bus_dout are 0.
- R2: bus_doe is 1 exactly while bus_cs_n is 0, bus_rw is 1 (1 = read, 0 = write) and bus_addr[5] is 0. With bus_doe at 1, bus_dout returns register bus_addr[2:0] when bus_addr[4:3] is 0, and 0 for offsets 8 to 31. With bus_doe at 0, bus_dout is 0.
- R3: A write cycle (bus_rw 0, bus_addr[5] 0, bus_addr[4:3] 0, offset 0 to 6) stores bus_din into the addressed register. The commit happens when bus_cs_n rises, and the new value is readable from the fourth clock edge after the rise.
- R4: A write cycle with bus_addr[5] set to 1 changes no register and no flag. A write cycle to user offsets 8 to 31 also changes nothing.
- R5: Every chip-select low period of at least 3 clocks, followed by a high gap of at least 3 clocks, commits exactly one write. This holds for short full-speed strobes and for long half-speed strobes alike.
- R6: The pending flag is set by a high level of evt_in at a clock edge, or by writing a value with bit 1 set to offset 7. irq_n is 0 while the flag is set and bit 0 of offset 6 is 1. The flag is held until software clears it.
- R7: Writing a value with bit 0 set to offset 7 clears the pending flag, and this clear takes priority over bit 1 of the same write. An evt_in pulse in the same cycle as a clear takes priority over the clear. Writing offset 7 with bit 0 at 0 does not clear the flag.
- R8: A read of offset 7 returns the pending flag in bit 0 and zeros in bits 7 to 1. Offset 7 has no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Active-low chip select from the host, asynchronous |
| bus_rw | input | 1 | 1 for a read, 0 for a write |
| bus_addr | input | 6 | Host address; bit 5 selects the reserved half |
| bus_din | input | 8 | Write data from the upper byte lane |
| bus_dout | output | 8 | Read data for the upper byte lane |
| bus_doe | output | 1 | Read data enable for the lane drivers |
| evt_in | input | 1 | Local event pulse that raises the interrupt |
| irq_n | output | 1 | Active-low, level-held interrupt request |

## Verification
Several properties are checked on every cycle: the data lane is zero whenever it is not enabled, a commit to the reserved half leaves the register bank unchanged, each synchronised strobe edge gives a single commit, an event always leaves the flag set, the flag holds until a clear, and a clear with no competing event drops it. Other behaviours only the bench scenarios can show. These are the full address-map read sweep, readback after writes made with short and with long strobes, the aliasing and reserved-write cases, and the interplay of enable, software set, software clear and the event pulse as seen on irq_n.

// File: rtl/exp_bus_slave.sv
module exp_bus_slave #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs_n,
  input  logic          bus_rw,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic          evt_in,
  output logic          irq_n
);
  localparam int OW   = $clog2(NREG);
  localparam int STAT = NREG - 1;
  localparam int CTRL = NREG - 2;
  localparam int PW   = 1 + AW + DW;

  logic [2:0]                cs_s;
  logic [PW-1:0]             p1, p2, hold;
  logic [NREG-2:0][DW-1:0]   regs;
  logic                      pend;

  logic          h_rw;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data;
  logic [OW-1:0] h_off;
  logic          wr_edge, wr_ok, clr, sset;

  assign {h_rw, h_addr, h_data} = hold;
  assign h_off   = h_addr[OW-1:0];
  assign wr_edge = cs_s[1] & ~cs_s[2];
  assign wr_ok   = wr_edge & ~h_rw & ~h_addr[AW-1] & (h_addr[AW-2:OW] == '0);
  assign clr     = wr_ok & (h_off == OW'(STAT)) & h_data[0];
  assign sset    = wr_ok & (h_off == OW'(STAT)) & h_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= 3'b111;
      p1   <= '0;
      p2   <= '0;
      hold <= '0;
    end else begin
      cs_s <= {cs_s[1:0], bus_cs_n};
      p1   <= {bus_rw, bus_addr, bus_din};
      p2   <= p1;
      if (!cs_s[1]) hold <= p2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NREG - 1; i++)
        if (wr_ok && h_off == OW'(i)) regs[i] <= h_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (evt_in) pend <= 1'b1;
    else if (clr)    pend <= 1'b0;
    else if (sset)   pend <= 1'b1;
  end

  assign irq_n = ~(pend & regs[CTRL][0]);

  logic          sel, in_range;
  logic [OW-1:0] off;
  logic [DW-1:0] rdata;

  assign sel      = ~bus_cs_n & bus_rw & ~bus_addr[AW-1];
  assign off      = bus_addr[OW-1:0];
  assign in_range = (bus_addr[AW-2:OW] == '0);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG - 1; i++)
      if (off == OW'(i)) rdata = regs[i];
    if (off == OW'(STAT)) rdata = {{(DW-1){1'b0}}, pend};
  end

  assign bus_doe  = sel;
  assign bus_dout = (sel && in_range) ? rdata : '0;

  assert_quiet_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_doe |-> (bus_dout == '0));

  assert_reserved_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_edge && h_addr[AW-1]) |=> $stable(regs));

  assert_one_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_edge |=> !wr_edge);

  assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_in |=> pend);

  assert_flag_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt_in) |=> !pend);
endmodule

// File: tb/test_exp_bus_slave.sv
`timescale 1ns/1ps
module test_exp_bus_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs_n = 1'b1;
  logic       bus_rw = 1'b1;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_doe;
  logic       evt_in = 1'b0;
  logic       irq_n;

  always #2.5 clk = ~clk;

  exp_bus_slave i_exp_bus_slave (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .evt_in(evt_in), .irq_n(irq_n)
  );

  int runs = 0, fails = 0;
  bit done = 0;
  logic [7:0] mdl [8];
  logic mpend = 1'b0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data(input logic [5:0] a);
    if (a[5] || a[4:3] != 2'b00) return 8'h00;
    if (a[2:0] == 3'd7) return {7'b0, mpend};
    return mdl[a[2:0]];
  endfunction

  function automatic logic exp_irq();
    return !(mpend && mdl[6][0]);
  endfunction

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d, input int low);
    @(negedge clk);
    bus_addr = a; bus_din = d; bus_rw = 1'b0; bus_cs_n = 1'b0;
    #1 check("R2 no drive on write", {7'b0, bus_doe, bus_dout}, 16'h0);
    repeat (low) @(negedge clk);
    bus_cs_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_rw = 1'b1;
    if (!a[5] && a[4:3] == 2'b00) begin
      if (a[2:0] == 3'd7) begin
        if (d[0]) mpend = 1'b0;
        else if (d[1]) mpend = 1'b1;
      end else mdl[a[2:0]] = d;
    end
  endtask

  task automatic bus_read(input logic [5:0] a, input string req);
    @(negedge clk);
    bus_addr = a; bus_rw = 1'b1; bus_cs_n = 1'b0;
    #1;
    check({req, " oe"}, {15'b0, bus_doe}, {15'b0, !a[5]});
    check({req, " data"}, {8'b0, bus_dout}, {8'b0, exp_data(a)});
    @(negedge clk);
    bus_cs_n = 1'b1;
  endtask

  task automatic pulse_evt();
    @(negedge clk); evt_in = 1'b1;
    @(negedge clk); evt_in = 1'b0;
    mpend = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    repeat (4) @(negedge clk);
    #1 check("R1 idle lane", {7'b0, bus_doe, bus_dout}, 16'h0);
    check("R1 irq in reset", {15'b0, irq_n}, 16'h1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) bus_read(6'(a), "R1 reset value");
    check("R1 irq after reset", {15'b0, irq_n}, 16'h1);

    // R3 / R5: short strobes fill offsets 0..6
    for (int a = 0; a < 7; a++) bus_write(6'(a), 8'((a * 37 + 5) & 8'hFE), 3);
    for (int a = 0; a < 64; a++) bus_read(6'(a), "R2 R3 sweep short");

    // R5: long half-speed strobes, exactly one commit per access
    for (int a = 0; a < 6; a++) bus_write(6'(a), 8'((a * 91 + 17) & 8'hFF), 12);
    for (int a = 0; a < 8; a++) bus_read(6'(a), "R5 long strobe");

    // R4: reserved half and aliased user offsets are ignored
    for (int a = 32; a < 64; a += 3) bus_write(6'(a), 8'hA5 ^ 8'(a), 3);
    for (int a = 8; a < 32; a += 5) bus_write(6'(a), 8'h5A ^ 8'(a), 3);
    bus_write(6'd39, 8'h02, 3);
    for (int a = 0; a < 8; a++) bus_read(6'(a), "R4 unchanged");
    check("R4 no irq from reserved", {15'b0, irq_n}, {15'b0, exp_irq()});

    // R6: event raises, enable gates irq_n, level held
    bus_write(6'd6, 8'h00, 3);
    pulse_evt();
    #1 check("R6 masked irq", {15'b0, irq_n}, 16'h1);
    bus_read(6'd7, "R8 status pending");
    bus_write(6'd6, 8'h01, 4);
    #1 check("R6 enabled irq", {15'b0, irq_n}, 16'h0);
    repeat (20) @(negedge clk);
    #1 check("R6 level held", {15'b0, irq_n}, 16'h0);

    // R7: bit0=0 does not clear; bit0=1 clears
    bus_write(6'd7, 8'hFC, 3);
    #1 check("R7 no clear", {15'b0, irq_n}, {15'b0, exp_irq()});
    bus_write(6'd7, 8'h01, 3);
    #1 check("R7 cleared", {15'b0, irq_n}, 16'h1);
    bus_read(6'd7, "R8 status clear");

    // R6: software set; R7: clear wins over set in one write
    bus_write(6'd7, 8'h02, 3);
    #1 check("R6 software set", {15'b0, irq_n}, 16'h0);
    bus_write(6'd7, 8'h03, 3);
    #1 check("R7 clear beats set", {15'b0, irq_n}, 16'h1);
    bus_read(6'd7, "R8 status after both");
    bus_read(6'd6, "R8 control readback");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      runs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule